// File: doc/BRIEF.md
# Serially Loaded Configuration Register with Readback Stream

This block holds the 16-bit setup word of a multichannel current-input converter. After a reset, and while the convert strobe stays low, software clocks a word in bit by bit over a dedicated configuration clock and data line. The word is applied only when exactly sixteen bits arrived and every unused bit is zero. The fields it carries go to the rest of the chip: a clock-divide select, a two-bit full-scale range, an output-width select, a version select and a test-mode bit.

The same setup window allows the word to be read back over the ordinary data clock and serial output. The readback frame is made of leading zeros, the register, a revision nibble and a fixed check signature. The frame is sent twice. After that the serial input is forwarded to the output, so several devices on one chain can all be read back. The first rising edge of the convert strobe ends the setup window. From then on the configuration and data clocks have no effect on this block.

All pins are sampled in the system clock domain. The configuration clock, the data clock and the convert strobe are edge-detected there, so each of their high and low phases must last at least one system clock.

Top module: `cfgreg_serial`

## Requirements
- R1: While reset is high and in the cycle after it, every decoded field, `cfg_done`, `cfg_err` and `dout` read 0.
- R2: A bit is taken from `cfg_din` at each falling edge of `cfg_clk`, most significant bit first. The write ends at the first rising edge of `dclk` or `conv`, whichever comes first. If the write is valid, all fields change together on the following clock and `cfg_done` rises.
- R3: The fields are decoded from fixed bit positions. Bit 13 drives `clk_div`. Bits 10:9 drive `fs_range`, coded 0, 1, 2, 3 for a full scale of 12.5, 50, 100 and 150 pC. Bit 8 drives `fmt_wide`, where 1 means 20-bit words. Bit 7 drives `version` and bit 0 drives `test_mode`.
- R4: If a write ends after some number of bits other than 0 or 16, `cfg_err` is set and the fields and `cfg_done` keep their old values. A write that ends with no bits changes nothing.
- R5: If a 16-bit word has any bit set outside positions 13, 10, 9, 8, 7 and 0, it is rejected: `cfg_err` rises and the fields keep their old values.
- R6: When `fmt_wide` is 0, the readback frame sends one bit per `dclk` rising edge in this order: 256 zeros, the 16 register bits starting at bit 15, the 4 revision bits starting at the most significant, 180 zeros, and then the 56 bits of 0x30F066012480F6 starting at the most significant bit. The frame is 512 bits and is sent twice.
- R7: When `fmt_wide` is 1, the frame order is: 320 zeros, the register, the revision, 228 zeros, and the 72 bits of 0x30F066012480F69055. The frame is 640 bits and is sent twice.
- R8: After both frames, each `dclk` rising edge copies the `din` level seen at that edge onto `dout`.
- R9: After the first `conv` rising edge, `cfg_clk` and `dclk` activity leaves every field unchanged and `dout` stays 0.
- R10: Configuration bits clocked in after the write has ended are ignored. The fields and flags keep the values that the ending produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; opens the setup window |
| conv | input | 1 | Convert strobe; its first rising edge closes setup |
| cfg_clk | input | 1 | Configuration bit clock |
| cfg_din | input | 1 | Configuration bit data |
| dclk | input | 1 | Data clock for readback |
| din | input | 1 | Serial input from the next device in the chain |
| dout | output | 1 | Serial readback output |
| clk_div | output | 1 | Clock-divide select |
| fs_range | output | 2 | Full-scale range code |
| fmt_wide | output | 1 | 1 = 20-bit output words |
| version | output | 1 | Version select |
| test_mode | output | 1 | Test-mode enable |
| cfg_done | output | 1 | A valid word has been applied |
| cfg_err | output | 1 | A write was rejected |

## Verification
The critical collision is the first `dclk` rising edge. In that one clock the write is judged and committed, and the first readback bit is sent. The frame is then sized by the format bit that was just committed. The bench writes words with a random format and starts readback immediately. It compares every bit of both frames, and the pass-through bits after them, against a frame model built from the written word. A second collision comes from clocking more configuration bits after that first edge: the bench checks that the fields still match the earlier word, while readback carries on from the next position.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int CFG_W    = 16;
    localparam int CNT_W    = 5;
    localparam int REV_W    = 4;
    localparam int IDX_W    = 11;

    localparam int LEAD_N   = 256;
    localparam int LEAD_W   = 320;
    localparam int GAP_N    = 180;
    localparam int GAP_W    = 228;
    localparam int SIG_N    = 56;
    localparam int SIG_W    = 72;

    localparam logic [SIG_W-1:0] SIGNATURE = 72'h30F066012480F69055;

    localparam logic [CFG_W-1:0] USED_MASK = 16'h2781;
    localparam logic [CFG_W-1:0] RSV_MASK  = ~USED_MASK;

    typedef enum logic [1:0] {
        PH_WRITE = 2'd0,
        PH_READ  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        FS_12P5 = 2'd0,
        FS_50   = 2'd1,
        FS_100  = 2'd2,
        FS_150  = 2'd3
    } fs_e;

    typedef struct packed {
        logic clk_div;
        fs_e  fs;
        logic wide;
        logic version;
        logic test;
    } fields_t;

    function automatic fields_t decode(input logic [CFG_W-1:0] w);
        fields_t f;
        f.clk_div = w[13];
        f.fs      = fs_e'(w[10:9]);
        f.wide    = w[8];
        f.version = w[7];
        f.test    = w[0];
        return f;
    endfunction

    function automatic logic [IDX_W-1:0] frame_len(input logic wide);
        return wide ? IDX_W'(LEAD_W + CFG_W + REV_W + GAP_W + SIG_W)
                    : IDX_W'(LEAD_N + CFG_W + REV_W + GAP_N + SIG_N);
    endfunction

    function automatic logic frame_bit(input logic             wide,
                                       input logic [CFG_W-1:0] w,
                                       input logic [REV_W-1:0] rev,
                                       input int               pos);
        int                 lead;
        int                 gap;
        int                 k;
        logic [CFG_W-1:0]   ws;
        logic [REV_W-1:0]   rs;
        logic [SIG_W-1:0]   ss;
        lead = wide ? LEAD_W : LEAD_N;
        gap  = wide ? GAP_W  : GAP_N;
        if (pos < lead) return 1'b0;
        k = pos - lead;
        if (k < CFG_W) begin
            ws = w >> (CFG_W - 1 - k);
            return ws[0];
        end
        k = k - CFG_W;
        if (k < REV_W) begin
            rs = rev >> (REV_W - 1 - k);
            return rs[0];
        end
        k = k - REV_W;
        if (k < gap) return 1'b0;
        k = k - gap;
        ss = SIGNATURE >> (SIG_W - 1 - k);
        return ss[0];
    endfunction

endpackage

// File: rtl/cfgreg_edge.sv
module cfgreg_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic pulse
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    generate
        if (RISE) begin : g_rise
            assign pulse = sig & ~sig_q;
        end else begin : g_fall
            assign pulse = ~sig & sig_q;
        end
    endgenerate
endmodule

// File: rtl/cfgreg_loader.sv
module cfgreg_loader
    import cfgreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_fall,
    input  logic             cfg_din,
    input  logic             dclk_rise,
    input  logic             conv_rise,
    output logic [CFG_W-1:0] word_q,
    output phase_e           phase_q,
    output logic             done_q,
    output logic             err_q
);
    logic [CFG_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             ends;
    logic             good;

    assign ends = (phase_q == PH_WRITE) && (dclk_rise || conv_rise);
    assign good = (cnt == CNT_W'(CFG_W)) && ((shreg & RSV_MASK) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            cnt     <= '0;
            word_q  <= '0;
            phase_q <= PH_WRITE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (conv_rise) begin
                phase_q <= PH_RUN;
            end else if (ends) begin
                phase_q <= PH_READ;
            end
            if (ends) begin
                if (good) begin
                    word_q <= shreg;
                    done_q <= 1'b1;
                end else if (cnt != '0) begin
                    err_q  <= 1'b1;
                end
            end else if (phase_q == PH_WRITE && cfg_fall) begin
                shreg <= {shreg[CFG_W-2:0], cfg_din};
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
        end
    end

    AST_WORD_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (word_q != $past(word_q)) |-> done_q);                                 // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q));                                                   // R4
    AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (word_q & RSV_MASK) == '0);                                            // R5
    AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN) |=> $stable(word_q));                              // R9
    AST_LATE_BITS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && !conv_rise) |=> $stable(word_q) && $stable(err_q)); // R10
endmodule

// File: rtl/cfgreg_unload.sv
module cfgreg_unload
    import cfgreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dclk_rise,
    input  logic             din,
    input  phase_e           phase,
    input  logic [CFG_W-1:0] word,
    input  logic [REV_W-1:0] rev,
    output logic             dout
);
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] total;
    logic [IDX_W-1:0] pos;
    logic             spent;

    assign len   = frame_len(word[8]);
    assign total = len << 1;
    assign pos   = (idx >= len) ? idx - len : idx;
    assign spent = (idx >= total);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            dout <= 1'b0;
        end else if (phase == PH_RUN) begin
            dout <= 1'b0;
        end else if (dclk_rise) begin
            if (!spent) begin
                dout <= frame_bit(word[8], word, rev, int'(pos));
                idx  <= idx + 1'b1;
            end else begin
                dout <= din;
            end
        end
    end

    AST_CHAIN_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_RUN && dclk_rise && spent) |=> (dout == $past(din)));    // R8
    AST_QUIET_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) |=> !dout);                                          // R9
    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx <= total);                                                         // R6
endmodule

// File: rtl/cfgreg_serial.sv
module cfgreg_serial
    import cfgreg_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'b1010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv,
    input  logic       cfg_clk,
    input  logic       cfg_din,
    input  logic       dclk,
    input  logic       din,
    output logic       dout,
    output logic       clk_div,
    output logic [1:0] fs_range,
    output logic       fmt_wide,
    output logic       version,
    output logic       test_mode,
    output logic       cfg_done,
    output logic       cfg_err
);
    logic             cfg_fall;
    logic             dclk_rise;
    logic             conv_rise;
    logic [CFG_W-1:0] word;
    phase_e           phase;
    fields_t          fld;

    cfgreg_edge #(.RISE(1'b0)) i_cfg_edge  (.clk(clk), .rst(rst), .sig(cfg_clk), .pulse(cfg_fall));
    cfgreg_edge #(.RISE(1'b1)) i_dclk_edge (.clk(clk), .rst(rst), .sig(dclk),    .pulse(dclk_rise));
    cfgreg_edge #(.RISE(1'b1)) i_conv_edge (.clk(clk), .rst(rst), .sig(conv),    .pulse(conv_rise));

    cfgreg_loader i_loader (
        .clk(clk), .rst(rst),
        .cfg_fall(cfg_fall), .cfg_din(cfg_din),
        .dclk_rise(dclk_rise), .conv_rise(conv_rise),
        .word_q(word), .phase_q(phase),
        .done_q(cfg_done), .err_q(cfg_err)
    );

    cfgreg_unload i_unload (
        .clk(clk), .rst(rst),
        .dclk_rise(dclk_rise), .din(din),
        .phase(phase), .word(word), .rev(REV_ID),
        .dout(dout)
    );

    assign fld       = decode(word);
    assign clk_div   = fld.clk_div;
    assign fs_range  = fld.fs;
    assign fmt_wide  = fld.wide;
    assign version   = fld.version;
    assign test_mode = fld.test;
endmodule

// File: tb/test_cfgreg_serial.sv
module test_cfgreg_serial;
    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] REV        = 4'b1010;

    logic       clk = 1'b0;
    logic       rst, conv, cfg_clk, cfg_din, dclk, din;
    logic       dout, clk_div, fmt_wide, version, test_mode, cfg_done, cfg_err;
    logic [1:0] fs_range;

    int vectors     = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgreg_serial #(.REV_ID(REV)) i_cfgreg_serial (
        .clk(clk), .rst(rst), .conv(conv), .cfg_clk(cfg_clk), .cfg_din(cfg_din),
        .dclk(dclk), .din(din), .dout(dout), .clk_div(clk_div), .fs_range(fs_range),
        .fmt_wide(fmt_wide), .version(version), .test_mode(test_mode),
        .cfg_done(cfg_done), .cfg_err(cfg_err)
    );

    function automatic int exp_len(input logic wide);
        return wide ? 640 : 512;
    endfunction

    function automatic logic exp_bit(input logic wide, input logic [15:0] w, input int p);
        logic [71:0] sig;
        int          z0, z1, s;
        sig = 72'h30F066012480F69055;
        z0  = wide ? 320 : 256;
        z1  = wide ? 228 : 180;
        s   = z0 + 16 + 4 + z1;
        if (p >= s)           return sig[71 - (p - s)];
        if (p >= z0 + 20)     return 1'b0;
        if (p >= z0 + 16)     return REV[3 - (p - z0 - 16)];
        if (p >= z0)          return w[15 - (p - z0)];
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_fields(input string req, input logic [15:0] w,
                              input logic done, input logic err);
        chk(req, {25'd0, clk_div, fs_range, fmt_wide, version, test_mode, cfg_done, cfg_err},
                 {25'd0, w[13], w[10:9], w[8], w[7], w[0], done, err});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; conv = 1'b0; cfg_clk = 1'b0; cfg_din = 1'b0; dclk = 1'b0; din = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic put_cfg(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); cfg_din = v[i]; cfg_clk = 1'b1;
            @(negedge clk); cfg_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse_dclk(input logic b, output logic d);
        @(negedge clk); din = b; dclk = 1'b1;
        @(negedge clk); d = dout; dclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic readback(input string req, input logic wide, input logic [15:0] w,
                            input int start, input int extra);
        logic b, d;
        int   n;
        int   bad;
        n   = exp_len(wide);
        bad = 0;
        for (int p = start; p < 2 * n + extra; p++) begin
            b = 1'($urandom);
            pulse_dclk(b, d);
            vectors++;
            if (d !== ((p < 2 * n) ? exp_bit(wide, w, p % n) : b)) begin
                miscompares++;
                bad++;
                if (bad < 4)
                    $display("FAIL %s: bit %0d actual %0b expected %0b", req, p, d,
                             (p < 2 * n) ? exp_bit(wide, w, p % n) : b);
            end
        end
    endtask

    function automatic logic [15:0] rand_word(input logic wide);
        logic [15:0] w;
        w    = 16'($urandom) & 16'h2781;
        w[8] = wide;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [15:0] w, w2;
        logic        d;
        void'($urandom(32'h1C0FFEE));

        do_reset();
        chk_fields("R1 reset fields", 16'h0000, 1'b0, 1'b0);
        chk("R1 reset dout", {31'd0, dout}, 32'd0);

        w = 16'h2681;
        put_cfg({16'd0, w}, 16);
        chk_fields("R2 no change before end", 16'h0000, 1'b0, 1'b0);
        readback("R6 narrow frame", 1'b0, w, 0, 8);
        chk_fields("R3 decode after dclk end", w, 1'b1, 1'b0);

        do_reset();
        w = 16'h2781;
        put_cfg({16'd0, w}, 16);
        @(negedge clk); conv = 1'b1;
        @(negedge clk);
        chk_fields("R2 commit on conv", w, 1'b1, 1'b0);
        put_cfg(32'h0000_0000, 16);
        pulse_dclk(1'b1, d);
        chk("R9 dout quiet after conv", {31'd0, d}, 32'd0);
        chk_fields("R9 fields frozen", w, 1'b1, 1'b0);

        do_reset();
        put_cfg(32'h0000_2681, 15);
        pulse_dclk(1'b0, d);
        chk_fields("R4 short write rejected", 16'h0000, 1'b0, 1'b1);

        do_reset();
        put_cfg(32'h0000_4D02, 17);
        pulse_dclk(1'b0, d);
        chk_fields("R4 long write rejected", 16'h0000, 1'b0, 1'b1);

        do_reset();
        pulse_dclk(1'b0, d);
        chk_fields("R4 empty write no error", 16'h0000, 1'b0, 1'b0);

        do_reset();
        put_cfg(32'h0000_2782, 16);
        pulse_dclk(1'b0, d);
        chk_fields("R5 reserved bit rejected", 16'h0000, 1'b0, 1'b1);

        do_reset();
        w  = 16'h0501;
        w2 = 16'h2281;
        put_cfg({16'd0, w}, 16);
        pulse_dclk(1'b1, d);
        chk("R2 first readback bit", {31'd0, d}, 32'd0);
        put_cfg({16'd0, w2}, 16);
        chk_fields("R10 late bits ignored", w, 1'b1, 1'b0);
        readback("R7 wide frame", 1'b1, w, 1, 6);
        readback("R8 chain forward", 1'b1, w, 1280, 10);

        for (int it = 0; it < 4; it++) begin
            logic wide;
            wide = 1'($urandom);
            w    = rand_word(wide);
            do_reset();
            put_cfg({16'd0, w}, 16);
            readback(wide ? "R7 random frame" : "R6 random frame", wide, w, 0, 4);
            chk_fields("R3 random decode", w, 1'b1, 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule